// File: doc/BRIEF.md
# Three-Channel Reloadable Interval Timer

This peripheral holds three identical 16-bit down-counting interval timers behind a byte-wide register bus. Each channel counts ticks of a clock enable chosen from a shared prescaler: every system clock, every 8th, or every 32nd. When a channel is at zero on a tick, it reloads from its 16-bit reload register and emits a one-clock overflow pulse. Each channel's overflow pulse is also passed to the next channel around a three-channel ring, so channel 0 sees channel 2's pulse.

Each channel is run by a small state machine with three states:
- **STOP**: the start flag is clear and the counter is frozen.
- **RUN**: the flag is set, the configuration is usable, and the counter advances.
- **HOLD**: the flag is set but the configuration cannot count, either because the operating mode is not timer mode or because the source code is reserved.

The transitions are:
- STOP→RUN: the flag is set and the configuration is valid.
- STOP→HOLD: the flag is set and the configuration is invalid.
- RUN→STOP and HOLD→STOP: the flag is cleared.
- RUN→HOLD: the configuration becomes invalid.
- HOLD→RUN: the configuration becomes valid again.

The state register changes one clock after the flag or the mode register changes.

Software writes the 16-bit reload value as two bytes. The low byte is staged, and the high-byte write commits both bytes together. A read of a counter address returns the live counter value.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every counter, reload value, mode register and start flag is 0, and no overflow or ring output is asserted.
- R2: Register addresses are fixed. Channel c has its low byte at address 2c and its high byte at 2c+1. Reads of either address return the live counter byte, and writes go to the reload value. The mode register of channel c is at 6+c. The start flags are bits 2:0 of address 9, one bit per channel (bit c enables channel c). Addresses 10 to 15 read as 0, and writes to them change nothing.
- R3: A write to the high byte sets the reload value to {high byte, last staged low byte}. A write to the low byte alone changes neither the reload value nor the counter. While a channel is stopped, a high-byte write also loads its counter.
- R4: On each tick, a running counter decrements by one. When it is 0 on a tick, it loads the reload value and asserts that channel's overflow output for one clock. With reload value R, consecutive pulses are therefore R+1 ticks apart.
- R5: Writing the reload value of a running channel does not touch its counter. The new value is used from the next underflow on. If the high-byte write lands on the same clock as an underflow, the counter loads the newly written value.
- R6: Mode bits 7:6 select the tick source: 00 ticks every clock, 01 every 8 clocks, 10 every 32 clocks, and 11 never ticks.
- R7: Clearing a channel's start flag freezes its counter. Setting the flag again resumes counting from the frozen value.
- R8: Only mode bits 1:0 = 00 (timer mode) counts; any other value holds the counter. Mode bits 3:2 have no effect on counting. Mode bit 5 always reads as 0.
- R9: Ring output bit i carries the overflow pulse of channel (i+2) mod 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ovf_pulse | output | 3 | One-clock overflow pulse per channel |
| chain_ovf | output | 3 | Overflow pulse of the preceding channel in the ring |

## Verification
An underflow reload and a software reload commit can fall on the same clock. To provoke this, a running channel is set to reload value 0, so it underflows on every clock at the fastest source. A low byte and then a high byte are then written. The commit edge is judged by two results: the counter must read the freshly written value right after that edge, and the following pulse spacing must match the new value plus one. Small reload values are also swept, and the pulse spacing and the post-pulse counter value are compared with the arithmetic period for each.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH        = 3;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int MODE_BASE  = 2 * NCH;
    localparam int FLAG_ADDR  = MODE_BASE + NCH;

    localparam logic [1:0] OPM_TIMER = 2'b00;
    localparam logic [1:0] SRC_F1    = 2'b00;
    localparam logic [1:0] SRC_F8    = 2'b01;
    localparam logic [1:0] SRC_F32   = 2'b10;
    localparam logic [1:0] SRC_NONE  = 2'b11;

    localparam logic [7:0] MODE_KEEP = 8'b1101_1111;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } chan_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] strobe
);
    localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] MID_MASK  = PW'(DIV_MID - 1);
    localparam logic [PW-1:0] SLOW_LAST = PW'(DIV_SLOW - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign strobe[0] = 1'b1;

    generate
        if (DIV_MID > 1) begin : g_mid
            assign strobe[1] = ((phase_q & MID_MASK) == MID_MASK);
        end else begin : g_mid_full
            assign strobe[1] = 1'b1;
        end
        if (DIV_SLOW > 1) begin : g_slow
            assign strobe[2] = (phase_q == SLOW_LAST);
        end else begin : g_slow_full
            assign strobe[2] = 1'b1;
        end
    endgenerate

    // R6: the slow strobe never lasts two clocks and always lines up with the mid strobe
    p_slow_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[2] |=> !strobe[2]);
    p_slow_in_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[2] |-> strobe[1]);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_flag,
    input  logic [1:0]   op_mode,
    input  logic [1:0]   src_sel,
    input  logic [2:0]   strobe,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wdata,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam int LO_W = W - 8;

    chan_state_e   state_q, state_d;
    logic [LO_W-1:0] stage_q;
    logic [W-1:0]  reload_q, cnt_q;
    logic          ovf_q;
    logic          tick, cfg_ok;
    logic [W-1:0]  fresh;

    assign fresh = {wdata, stage_q};

    always_comb begin
        unique case (src_sel)
            SRC_F1:   tick = strobe[0];
            SRC_F8:   tick = strobe[1];
            SRC_F32:  tick = strobe[2];
            SRC_NONE: tick = 1'b0;
        endcase
    end

    assign cfg_ok = (op_mode == OPM_TIMER) && (src_sel != SRC_NONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_flag) state_d = cfg_ok ? ST_RUN : ST_HOLD;
            ST_RUN:  if (!run_flag) state_d = ST_STOP;
                     else if (!cfg_ok) state_d = ST_HOLD;
            ST_HOLD: if (!run_flag) state_d = ST_STOP;
                     else if (cfg_ok) state_d = ST_RUN;
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (wr_lo) stage_q <= wdata[LO_W-1:0];
            if (wr_hi) reload_q <= fresh;
            unique case (state_q)
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            cnt_q <= wr_hi ? fresh : reload_q;
                            ovf_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_STOP, ST_HOLD: begin
                    if (wr_hi) cnt_q <= fresh;
                end
                default: ;
            endcase
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    // R4: a pulse always leaves the counter holding the reload value
    p_ovf_reloads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == reload_q));
    // R7: without RUN and without a commit, the counter does not move
    p_stop_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !wr_hi) |=> $stable(cnt_q));
    // R8: RUN is only entered while the configuration can count
    p_run_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) ##1 (state_q == ST_RUN) |-> $past(cfg_ok));
    // R4: no pulse without a run state in the previous clock
    p_ovf_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $past(state_q == ST_RUN));

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [2:0]  ovf_pulse,
    output logic [2:0]  chain_ovf
);
    logic [2:0]        strobe;
    logic [NCH-1:0]    flags_q;
    logic [7:0]        mode_q [NCH];
    logic [CNT_W-1:0]  cnt    [NCH];
    logic [NCH-1:0]    wr_lo, wr_hi, ovf;

    tmr_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            for (int c = 0; c < NCH; c++) mode_q[c] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(FLAG_ADDR)) flags_q <= reg_wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++)
                if (reg_addr == ADDR_W'(MODE_BASE + c)) mode_q[c] <= reg_wdata & MODE_KEEP;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign wr_lo[c] = reg_wr && (reg_addr == ADDR_W'(2 * c));
            assign wr_hi[c] = reg_wr && (reg_addr == ADDR_W'(2 * c + 1));

            tmr_channel #(.W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .run_flag (flags_q[c]),
                .op_mode  (mode_q[c][1:0]),
                .src_sel  (mode_q[c][7:6]),
                .strobe   (strobe),
                .wr_lo    (wr_lo[c]),
                .wr_hi    (wr_hi[c]),
                .wdata    (reg_wdata),
                .count    (cnt[c]),
                .ovf      (ovf[c])
            );

            assign chain_ovf[c] = ovf[(c + NCH - 1) % NCH];
        end
    endgenerate

    assign ovf_pulse = ovf;

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == ADDR_W'(2 * c))          reg_rdata = cnt[c][7:0];
            if (reg_addr == ADDR_W'(2 * c + 1))      reg_rdata = cnt[c][15:8];
            if (reg_addr == ADDR_W'(MODE_BASE + c))  reg_rdata = mode_q[c];
        end
        if (reg_addr == ADDR_W'(FLAG_ADDR)) reg_rdata = {{(8-NCH){1'b0}}, flags_q};
    end

    // R8: mode bit 5 never reads back as 1
    p_mode_bit5_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(MODE_BASE) && reg_addr < ADDR_W'(FLAG_ADDR)) |-> !reg_rdata[5]);
    // R2: unmapped addresses read as zero
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(FLAG_ADDR)) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/tb_tri_interval_timer.sv
`timescale 1ns/100ps
module tb_tri_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] ovf_pulse, chain_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tri_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ovf_pulse(ovf_pulse), .chain_ovf(chain_ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 4'(a);
        #0.2;
        d = int'(reg_rdata);
    endtask

    task automatic rd_cnt(input int ch, output int v);
        int lo, hi;
        rd(2 * ch, lo);
        rd(2 * ch + 1, hi);
        v = hi * 256 + lo;
    endtask

    task automatic set_reload(input int ch, input int v);
        wr(2 * ch, v & 8'hFF);
        wr(2 * ch + 1, (v >> 8) & 8'hFF);
    endtask

    task automatic wait_pulse(input int ch, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!ovf_pulse[ch] && gap < 200);
    endtask

    task automatic rate(input int ch, input int cyc, output int delta);
        int a, b;
        repeat (5) @(negedge clk);
        rd_cnt(ch, a);
        repeat (cyc) @(negedge clk);
        rd_cnt(ch, b);
        delta = a - b;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, d, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            check("R1 reg", v, 0);
        end
        check("R1 ovf", int'(ovf_pulse), 0);
        check("R1 chain", int'(chain_ovf), 0);

        // R2: unmapped reads and writes
        wr(12, 8'hFF);
        for (int a = 10; a < 16; a++) begin
            rd(a, v);
            check("R2 unmapped", v, 0);
        end
        rd(9, v);  check("R2 flags untouched", v, 0);
        rd(6, v);  check("R2 mode untouched", v, 0);

        // R3: staging and stopped commit
        wr(0, 8'h34);
        rd_cnt(0, v); check("R3 low only", v, 0);
        wr(1, 8'h12);
        rd_cnt(0, v); check("R3 commit loads stopped counter", v, 16'h1234);

        // R8: bit 5 reads 0, other bits kept
        wr(7, 8'hFF); rd(7, v); check("R8 bit5 read", v, 8'hDF);
        wr(7, 8'h00);

        // R6: source rates, R8: bits 3:2 no effect
        set_reload(0, 16'h1000);
        set_reload(1, 16'h2000);
        set_reload(2, 16'h3000);
        wr(6, 8'h0C);
        wr(7, 8'h40);
        wr(8, 8'h80);
        wr(9, 8'h07);
        rate(0, 100, d); check("R6 f1 and R8 bits3:2", d, 100);
        rate(1, 64, d);  check("R6 f8", d, 8);
        rate(2, 64, d);  check("R6 f32", d, 2);
        wr(6, 8'hC0);
        rate(0, 64, d);  check("R6 reserved source", d, 0);
        wr(6, 8'h01);
        rate(0, 64, d);  check("R8 non-timer mode", d, 0);
        wr(6, 8'h00);
        rate(0, 40, d);  check("R8 back to timer", d, 40);

        // R7: freeze and resume
        wr(9, 8'h00);
        rate(0, 20, d);  check("R7 frozen", d, 0);
        wr(9, 8'h01);
        rate(0, 20, d);  check("R7 resumed", d, 20);

        // R4: sweep of small reload values
        for (int r = 0; r < 8; r++) begin
            wr(9, 8'h00);
            set_reload(0, r);
            wr(9, 8'h01);
            wait_pulse(0, g);
            rd_cnt(0, v); check("R4 counter after pulse", v, r);
            wait_pulse(0, g); check("R4 period", g, r + 1);
            wait_pulse(0, g); check("R4 period again", g, r + 1);
        end

        // R5: running reload change takes effect at next underflow
        wr(9, 8'h00);
        set_reload(0, 5);
        wr(9, 8'h01);
        wait_pulse(0, g);
        set_reload(0, 9);
        wait_pulse(0, g);
        wait_pulse(0, g); check("R5 new period", g, 10);

        // R5: commit collides with underflow
        wr(9, 8'h00);
        set_reload(0, 0);
        wr(9, 8'h01);
        repeat (4) @(negedge clk);
        check("R5 pulse every clock", int'(ovf_pulse[0]), 1);
        wr(0, 8'h07);
        wr(1, 8'h00);
        rd_cnt(0, v); check("R5 collision loads fresh value", v, 7);
        check("R5 collision pulse", int'(ovf_pulse[0]), 1);
        wait_pulse(0, g); check("R5 period after collision", g, 8);

        // R9: ring routing
        wr(9, 8'h00);
        set_reload(2, 0);
        wr(8, 8'h00);
        wr(9, 8'h04);
        repeat (4) @(negedge clk);
        check("R9 ch2 pulses", int'(ovf_pulse), 4);
        check("R9 ch0 sees ch2", int'(chain_ovf), 1);
        wr(9, 8'h00);
        set_reload(0, 0);
        wr(9, 8'h01);
        repeat (4) @(negedge clk);
        check("R9 ch1 sees ch0", int'(chain_ovf), 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule